// File: doc/BRIEF.md
# Compact Timer with PWM Modes

This block is a 10-bit up-counting timer with two comparators. Comparator A takes a full 10-bit compare value. Comparator P takes a 3-bit coarse code that is scaled by 128 counts. The counter moves forward only on cycles where the prescaled clock-enable input is high. A run bit that is low holds the counter at zero. Each comparator raises its own sticky interrupt flag whenever it matches. Each flag is cleared by a write-one-to-clear pulse.

A 2-bit mode field selects the operating mode.

- **PWM output mode:** a swap bit decides which comparator sets the period and which sets the duty. The period comparator always restarts the counter. The waveform is edge-aligned: it is active from count 0 until the count reaches the duty value. Three controls shape the pin:
  - an active-level bit,
  - a 2-bit field that enables the waveform or forces the pin low or high,
  - a final inversion bit.
- **Other modes:** the timer keeps counting and raising flags. The pin is not driven. A clear-select bit picks which comparator restarts the counter.

All configuration arrives on plain input ports. The count, the flags, the pin and the pin-enable are registered outputs.

Top module: `cpwm_timer`

## Requirements
- R1: After reset the count, both flags, the pin and the pin-enable are 0.
- R2: With run high the count rises by one on each cycle where tick is high and holds otherwise. With run low the count is forced to 0. The count wraps from 1023 to 0.
- R3: Comparator A matches on a run-and-tick cycle on which count+1 (mod 1024) equals the A value. Comparator P matches likewise against code×128 (mod 1024). Flag A and flag P each set on their own match and stay set until their clear input is high. A set and a clear in the same cycle leave the flag set.
- R4: In PWM mode (mode=2'b10) with swap=0, the P code sets the period as code×128 counts, and code 3'b000 gives 1024. The P match restarts the counter at 0, and the A value is the duty.
- R5: In PWM mode with swap=1, the A value sets the period, and A=0 gives 1024. The A match restarts the counter, and the duty is P code×128, so P code 3'b000 gives 0% duty.
- R6: In PWM mode the waveform is active while count < duty. A duty equal to or above the period keeps it active for the whole period.
- R7: The level bit gives the active level of the waveform: 1 means active-high and 0 means active-low.
- R8: The output-control field works as follows: 2'b00 forces the pin low, 2'b01 forces it high, and 2'b10 or 2'b11 passes the waveform.
- R9: The invert bit inverts the pin after level selection and forcing.
- R10: In any mode other than 2'b10 (2'b11 is timer/counter mode), the pin-enable and the pin are 0. The counter is restarted by the A match when clear-select is 1, or by the P match when it is 0.
- R11: In PWM mode the clear-select bit has no effect.
- R12: With P code 3'b100, A=128, swap=0 and tick always high, the period is 512 cycles and the pin is high for 128 of them (25%).
- R13: The pin and the pin-enable reflect the count value shown in the same cycle and the configuration present at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable |
| run | input | 1 | Counter run; low holds count at 0 |
| mode | input | 2 | 2'b10 PWM, 2'b11 timer/counter, others treated as timer/counter |
| swap | input | 1 | PWM role swap: 0 means P=period and A=duty; 1 means A=period and P=duty |
| clr_sel | input | 1 | Non-PWM restart source: 1 means A match, 0 means P match |
| act_lvl | input | 1 | Waveform active level |
| invert | input | 1 | Final output inversion |
| out_ctl | input | 2 | 00 force low, 01 force high, 1x waveform |
| cmp_a | input | 10 | Comparator A value |
| cmp_p | input | 3 | Comparator P coarse code (×128) |
| clr_flag_a | input | 1 | Write-one-to-clear for flag A |
| clr_flag_p | input | 1 | Write-one-to-clear for flag P |
| count | output | 10 | Current counter value |
| flag_a | output | 1 | Sticky comparator A match flag |
| flag_p | output | 1 | Sticky comparator P match flag |
| pin | output | 1 | Timer output pin value |
| pin_en | output | 1 | High when the timer drives the pin |

## Verification
The main stimulus is random segments. Each segment draws the mode, swap bit, compare values, output controls and clear-select, then runs with a random tick pattern and sparse random flag clears.

- Small A values produce frequent matches and wraps.
- Random P codes, including code 0, cover the 1024-count boundary and separate a wrap bug from a restart bug.
- Toggling clear-select during PWM segments exposes any leak of that bit into PWM mode.

Directed runs cover four further cases:
- the 25% reference waveform, measured by its period length and its high time;
- a coarse period of 128;
- duty at or above the period, and a zero P duty under swap;
- every combination of force field, level bit and inversion, which tells the three pin controls apart.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef enum logic [1:0] {
    MODE_CMP = 2'b00,
    MODE_CAP = 2'b01,
    MODE_PWM = 2'b10,
    MODE_TMR = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] OC_LOW  = 2'b00;
  localparam logic [1:0] OC_HIGH = 2'b01;
endpackage

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
  parameter int CNT_W = 10,
  parameter int PC_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             pwm,
  input  logic             swap,
  input  logic             clr_sel,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [PC_W-1:0]  cmp_p,
  output logic [CNT_W-1:0] p_val,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match_a,
  output logic             match_p
);
  localparam int SHIFT = CNT_W - PC_W;

  logic [CNT_W-1:0] inc;
  logic             a_restarts;
  logic             restart;

  assign p_val   = {cmp_p, {SHIFT{1'b0}}};
  assign inc     = cnt_q + CNT_W'(1);
  assign match_a = run && tick && (inc == cmp_a);
  assign match_p = run && tick && (inc == p_val);

  // PWM: period role follows swap; otherwise clear-select decides
  assign a_restarts = pwm ? swap : clr_sel;
  assign restart    = a_restarts ? match_a : match_p;

  always_comb begin
    if (!run)         cnt_d = '0;
    else if (!tick)   cnt_d = cnt_q;
    else if (restart) cnt_d = '0;
    else              cnt_d = inc;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));

  p_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(cnt_q));

  p_pwm_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (run && tick && pwm && !swap && (cnt_q + CNT_W'(1) == {cmp_p, {SHIFT{1'b0}}}))
    |=> (cnt_q == '0));
endmodule

// File: rtl/ctmr_flags.sv
module ctmr_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= (q[i] & ~clr[i]) | set[i];
    end

    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      (q[i] && !clr[i]) |=> q[i]);

    p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/ctmr_pinout.sv
module ctmr_pinout #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm,
  input  logic             swap,
  input  logic             act_lvl,
  input  logic             invert,
  input  logic [1:0]       out_ctl,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] a_val,
  input  logic [CNT_W-1:0] p_val,
  output logic             pin_q,
  output logic             en_q
);
  import ctmr_pkg::*;

  logic [CNT_W-1:0] duty;
  logic             active;
  logic             shaped;
  logic             chosen;

  assign duty   = swap ? p_val : a_val;
  assign active = cnt_d < duty;
  assign shaped = active ? act_lvl : ~act_lvl;
  assign chosen = out_ctl[1] ? shaped : out_ctl[0];

  // registered from the next count so pin lines up with count
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      pin_q <= pwm ? (chosen ^ invert) : 1'b0;
      en_q  <= pwm;
    end
  end

  p_no_drive_r10: assert property (@(posedge clk) disable iff (rst)
    !pwm |=> (!pin_q && !en_q));

  p_force_low_r8: assert property (@(posedge clk) disable iff (rst)
    (pwm && out_ctl == OC_LOW && !invert) |=> !pin_q);

  p_force_high_r9: assert property (@(posedge clk) disable iff (rst)
    (pwm && out_ctl == OC_HIGH && invert) |=> !pin_q);
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer #(
  parameter int CNT_W = 10,
  parameter int PC_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic             swap,
  input  logic             clr_sel,
  input  logic             act_lvl,
  input  logic             invert,
  input  logic [1:0]       out_ctl,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [PC_W-1:0]  cmp_p,
  input  logic             clr_flag_a,
  input  logic             clr_flag_p,
  output logic [CNT_W-1:0] count,
  output logic             flag_a,
  output logic             flag_p,
  output logic             pin,
  output logic             pin_en
);
  import ctmr_pkg::*;

  localparam int NFLAG = 2;

  logic             pwm;
  logic [CNT_W-1:0] p_val;
  logic [CNT_W-1:0] cnt_d;
  logic             match_a;
  logic             match_p;
  logic [NFLAG-1:0] flags;

  assign pwm = (mode == MODE_PWM);

  ctmr_counter #(.CNT_W(CNT_W), .PC_W(PC_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .pwm(pwm), .swap(swap),
    .clr_sel(clr_sel), .cmp_a(cmp_a), .cmp_p(cmp_p), .p_val(p_val),
    .cnt_d(cnt_d), .cnt_q(count), .match_a(match_a), .match_p(match_p)
  );

  ctmr_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst),
    .set({match_p, match_a}),
    .clr({clr_flag_p, clr_flag_a}),
    .q(flags)
  );

  assign flag_a = flags[0];
  assign flag_p = flags[1];

  ctmr_pinout #(.CNT_W(CNT_W)) u_pin (
    .clk(clk), .rst(rst), .pwm(pwm), .swap(swap), .act_lvl(act_lvl),
    .invert(invert), .out_ctl(out_ctl), .cnt_d(cnt_d), .a_val(cmp_a),
    .p_val(p_val), .pin_q(pin), .en_q(pin_en)
  );
endmodule

// File: tb/tb_cpwm_timer.sv
module tb_cpwm_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, run = 1'b0, swap = 1'b0, clr_sel = 1'b0;
  logic act_lvl = 1'b1, invert = 1'b0;
  logic [1:0] mode = 2'b10, out_ctl = 2'b10;
  logic [9:0] cmp_a = '0;
  logic [2:0] cmp_p = '0;
  logic clr_flag_a = 1'b0, clr_flag_p = 1'b0;
  logic [9:0] count;
  logic flag_a, flag_p, pin, pin_en;

  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;

  logic [9:0] m_cnt;
  logic m_fa, m_fp, m_pin, m_en;

  always #2 clk = ~clk;

  cpwm_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .mode(mode), .swap(swap),
    .clr_sel(clr_sel), .act_lvl(act_lvl), .invert(invert), .out_ctl(out_ctl),
    .cmp_a(cmp_a), .cmp_p(cmp_p), .clr_flag_a(clr_flag_a),
    .clr_flag_p(clr_flag_p), .count(count), .flag_a(flag_a), .flag_p(flag_p),
    .pin(pin), .pin_en(pin_en)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [9:0] coarse(input logic [2:0] c);
    return {c, 7'b0};
  endfunction

  // reference model advance from current inputs, then compare after the edge
  task automatic step(input string tag);
    logic [9:0] inc, pv, duty, nxt;
    logic ma, mp, rs, pw, act, lv, raw;
    pw  = (mode == 2'b10);
    pv  = coarse(cmp_p);
    inc = m_cnt + 10'd1;
    ma  = run && tick && (inc == cmp_a);
    mp  = run && tick && (inc == pv);
    rs  = (pw ? swap : clr_sel) ? ma : mp;
    if (!run)      nxt = '0;
    else if (!tick) nxt = m_cnt;
    else if (rs)   nxt = '0;
    else           nxt = inc;
    duty = swap ? pv : cmp_a;
    act  = nxt < duty;
    lv   = act ? act_lvl : ~act_lvl;
    raw  = out_ctl[1] ? lv : out_ctl[0];
    m_pin = pw ? (raw ^ invert) : 1'b0;
    m_en  = pw;
    m_fa  = (m_fa & ~clr_flag_a) | ma;
    m_fp  = (m_fp & ~clr_flag_p) | mp;
    m_cnt = nxt;
    @(posedge clk);
    #1;
    chk("R2 count", int'(count), int'(m_cnt));
    chk("R3 flag_a", int'(flag_a), int'(m_fa));
    chk("R3 flag_p", int'(flag_p), int'(m_fp));
    chk({tag, " pin"}, int'(pin), int'(m_pin));
    chk("R10 pin_en", int'(pin_en), int'(m_en));
  endtask

  task automatic cfg(input logic [1:0] md, input logic sw, input logic [9:0] a,
                     input logic [2:0] p, input logic [1:0] oc, input logic lv,
                     input logic iv);
    mode = md; swap = sw; cmp_a = a; cmp_p = p; out_ctl = oc;
    act_lvl = lv; invert = iv;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int highs, first_zero;
    void'($urandom(32'd2024));
    m_cnt = '0; m_fa = 1'b0; m_fp = 1'b0; m_pin = 1'b0; m_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 flag_a", int'(flag_a), 0);
    chk("R1 flag_p", int'(flag_p), 0);
    chk("R1 pin", int'(pin), 0);
    chk("R1 pin_en", int'(pin_en), 0);
    rst = 1'b0;

    // R12 reference waveform: P=100, A=128, continuous tick
    cfg(2'b10, 1'b0, 10'd128, 3'b100, 2'b10, 1'b1, 1'b0);
    tick = 1'b1; run = 1'b0;
    step("R13");
    run = 1'b1;
    highs = 0; first_zero = -1;
    for (int i = 1; i <= 1024; i++) begin
      step("R12");
      if (i <= 512 && pin) highs++;
      if (first_zero < 0 && count == 10'd0) first_zero = i;
    end
    chk("R12 period", first_zero, 512);
    chk("R12 high time", highs, 128);
    clr_flag_a = 1'b1; clr_flag_p = 1'b1;
    step("R3");
    clr_flag_a = 1'b0; clr_flag_p = 1'b0;

    // R4 coarse period 128 and R11 clear-select ignored
    run = 1'b0; step("R4");
    run = 1'b1; clr_sel = 1'b1;
    cfg(2'b10, 1'b0, 10'd40, 3'b001, 2'b10, 1'b1, 1'b0);
    for (int i = 1; i <= 300; i++) begin
      step("R11");
      if (i == 128) chk("R4 wrap at 128", int'(count), 0);
    end

    // R6 duty >= period, R5 swap with zero P duty
    cfg(2'b10, 1'b0, 10'd900, 3'b010, 2'b10, 1'b1, 1'b0);
    for (int i = 0; i < 300; i++) begin
      step("R6");
      chk("R6 full duty", int'(pin), 1);
    end
    cfg(2'b10, 1'b1, 10'd200, 3'b000, 2'b10, 1'b1, 1'b0);
    for (int i = 0; i < 300; i++) begin
      step("R5");
      chk("R5 zero duty", int'(pin), 0);
    end
    cfg(2'b10, 1'b1, 10'd300, 3'b001, 2'b10, 1'b0, 1'b0);
    for (int i = 0; i < 400; i++) step("R5");

    // R7 R8 R9 every pin control combination
    for (int k = 0; k < 16; k++) begin
      cfg(2'b10, 1'b0, 10'd64, 3'b001, k[1:0], k[2], k[3]);
      for (int i = 0; i < 70; i++) step(k[1] ? "R7" : (k[3] ? "R9" : "R8"));
    end

    // R10 timer/counter mode with each restart source
    cfg(2'b11, 1'b0, 10'd50, 3'b001, 2'b01, 1'b1, 1'b0);
    clr_sel = 1'b1;
    for (int i = 0; i < 200; i++) step("R10");
    clr_sel = 1'b0;
    for (int i = 0; i < 300; i++) step("R10");

    // random segments
    for (int s = 0; s < 40; s++) begin
      logic [1:0] md;
      md = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b10;
      cfg(md, 1'($urandom), ($urandom_range(0, 1) == 1) ? 10'($urandom_range(0, 200))
                                                       : 10'($urandom),
          3'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
      for (int i = 0; i < 400; i++) begin
        tick       = ($urandom_range(0, 7) != 0);
        run        = ($urandom_range(0, 199) != 0);
        clr_sel    = 1'($urandom);
        clr_flag_a = ($urandom_range(0, 15) == 0);
        clr_flag_p = ($urandom_range(0, 15) == 0);
        step(md == 2'b10 ? "R6" : "R10");
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule